// File: doc/BRIEF.md
# I2C Transaction Sequencer

This block walks a status-coded I2C master engine through one whole read or write transfer, so that no processor has to service each engine interrupt. A request carries a device address, a flag that selects 7-bit or 10-bit addressing, the direction, the byte count and an abort level. Each time the engine raises its interrupt flag, the sequencer reads the engine's status code. From that code it chooses the next step: load an address byte, load a data byte, store a received byte, continue, or stop. It then issues the matching control-register write.

The data bytes live outside the block in a buffer addressed through `buf_idx`. Bytes to transmit are read combinationally from `buf_rdata`. Received bytes leave through the `buf_wr` / `buf_wdata` strobe. The request port is a valid/ready handshake. `req_ready` is high only while no transfer is running and the engine flag is not being serviced, and a request is taken on a cycle where both `req_valid` and `req_ready` are high. There is no back-pressure anywhere else: the engine and buffer strobes are single-cycle pulses that the neighbours must accept. When a transfer ends, `done` pulses once and `result` gives 0 for success, 1 for no device or 2 for an I/O error.

Top module: `i2c_xfer_seq`

## Requirements
- R1: A request is accepted only while idle. The cycle after acceptance, the block writes control with start, acknowledge-enable and interrupt-enable set, and `req_ready` is low. A request presented while busy has no effect on the running transfer.
- R2: On status 0x08 or 0x10, the block loads the first address byte. In 7-bit mode this byte is `{addr[6:0], rd}`.
- R3: In 10-bit mode the first address byte is `0xF0 | addr[9:8]<<1 | rd`. On status 0x18 or 0x40, the block loads the second byte, `addr[7:0]`, instead of any data.
- R4: In a write, on status 0x18 (7-bit), 0xD0 or 0x28 with bytes remaining, the block loads the buffer byte at `buf_idx`. The index starts at 0 and rises by one for each byte.
- R5: In a write, a stop with result 0 is issued on those codes when no bytes remain, or when abort is high and at least one byte has been sent.
- R6: In a read, on status 0x40 (7-bit) or 0xE0, a zero length ends in a stop with result 0 (probe). Otherwise the block issues a continue write, with acknowledge-enable cleared if one byte remains or abort is high.
- R7: On status 0x50, the received byte is stored at the current index, and the index then rises. Acknowledge-enable is cleared when one byte would then remain, or when abort is high.
- R8: On status 0x58, the block stores the final byte, clears interrupt-enable and issues a stop with result 0.
- R9: Status 0x20, 0x30 or 0x48 causes a stop with result 1.
- R10: Any other status causes a stop, a one-cycle `eng_reinit` pulse and result 2.
- R11: A flagged status while idle causes only a stop write, with no `done`.
- R12: `done` is high for exactly one cycle. `result` holds its value until the next request is accepted, at which point it returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 10 | Device address |
| req_ten | input | 1 | 10-bit addressing |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_len | input | LEN_W | Byte count |
| abort_i | input | 1 | Abort level |
| eng_status | input | 8 | Engine status code |
| eng_iflg | input | 1 | Engine interrupt flag |
| eng_rdata | input | 8 | Engine received byte |
| data_we | output | 1 | Load `data_out` into engine data register |
| data_out | output | 8 | Byte for the engine |
| ctl_we | output | 1 | Control-register write strobe |
| ctl_start | output | 1 | Start bit of the control write |
| ctl_stop | output | 1 | Stop bit of the control write |
| ctl_ack | output | 1 | Acknowledge-enable bit |
| ctl_inten | output | 1 | Interrupt-enable bit |
| eng_reinit | output | 1 | Engine re-initialise pulse |
| buf_idx | output | LEN_W | Buffer byte index |
| buf_rdata | input | 8 | Buffer byte at `buf_idx` |
| buf_wr | output | 1 | Store `buf_wdata` at `buf_idx` |
| buf_wdata | output | 8 | Received byte |
| done | output | 1 | Transfer finished pulse |
| result | output | 2 | 0 ok, 1 no device, 2 I/O error |

## Verification
Every engine-side result (address or data load, control write, store strobe, `done`, `result`, `eng_reinit`) is registered once. It appears on the cycle after the first rising edge that samples `eng_iflg` high, and it lasts for one cycle. The byte index moves one cycle after that. The bench raises the flag on a falling edge and reads every output on the next falling edge. It then drops the flag and, one cycle later, checks that `done` has fallen and that `result` has held. The start write is checked on the falling edge after the accepting edge.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_NODEV = 2'd1,
    RES_IOERR = 2'd2
  } res_e;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_WA_ACK  = 8'h18;
  localparam logic [7:0] ST_WA_NAK  = 8'h20;
  localparam logic [7:0] ST_WD_ACK  = 8'h28;
  localparam logic [7:0] ST_WD_NAK  = 8'h30;
  localparam logic [7:0] ST_RA_ACK  = 8'h40;
  localparam logic [7:0] ST_RA_NAK  = 8'h48;
  localparam logic [7:0] ST_RD_ACK  = 8'h50;
  localparam logic [7:0] ST_RD_NAK  = 8'h58;
  localparam logic [7:0] ST_WA2_ACK = 8'hD0;
  localparam logic [7:0] ST_RA2_ACK = 8'hE0;
endpackage

// File: rtl/i2cs_addr_form.sv
module i2cs_addr_form #(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ten,
  input  logic              rd,
  output logic [7:0]        first_b,
  output logic [7:0]        second_b
);
  localparam logic [7:0] TEN_PREFIX = 8'hF0;

  always_comb begin
    if (ten) begin
      first_b  = TEN_PREFIX | {5'd0, addr[9:8], 1'b0} | {7'd0, rd};
      second_b = addr[7:0];
    end else begin
      first_b  = {addr[6:0], rd};
      second_b = 8'd0;
    end
  end
endmodule

// File: rtl/i2cs_byte_cnt.sv
module i2cs_byte_cnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             adv,
  output logic [LEN_W-1:0] remain,
  output logic [LEN_W-1:0] pos
);
  localparam logic [LEN_W-1:0] ZERO = '0;
  localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= ZERO;
      pos    <= ZERO;
    end else if (load) begin
      remain <= len;
      pos    <= ZERO;
    end else if (adv) begin
      if (remain != ZERO) remain <= remain - ONE;
      pos <= pos + ONE;
    end
  end
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2cs_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_ten,
  input  logic              req_rd,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              abort_i,
  input  logic [7:0]        eng_status,
  input  logic              eng_iflg,
  input  logic [7:0]        eng_rdata,
  output logic              data_we,
  output logic [7:0]        data_out,
  output logic              ctl_we,
  output logic              ctl_start,
  output logic              ctl_stop,
  output logic              ctl_ack,
  output logic              ctl_inten,
  output logic              eng_reinit,
  output logic [LEN_W-1:0]  buf_idx,
  input  logic [7:0]        buf_rdata,
  output logic              buf_wr,
  output logic [7:0]        buf_wdata,
  output logic              done,
  output logic [1:0]        result
);
  localparam logic [LEN_W-1:0] ZERO = '0;
  localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO  = LEN_W'(2);

  logic              busy, armed, act, accept;
  logic [ADDR_W-1:0] addr_q;
  logic              ten_q, rd_q;
  logic              ack_en, inten, adv_q;
  logic [LEN_W-1:0]  remain, pos;
  logic [7:0]        first_b, second_b;

  logic d_send1, d_send2, d_data, d_cont, d_store, d_stop;
  logic d_clr_ack, d_adv, d_reinit;
  res_e d_res;

  assign act       = eng_iflg && armed;
  assign req_ready = !busy && !act;
  assign accept    = req_valid && req_ready;
  assign buf_idx   = pos;
  assign ctl_ack   = ack_en;
  assign ctl_inten = inten;

  i2cs_addr_form #(.ADDR_W(ADDR_W)) u_addr (
    .addr(addr_q), .ten(ten_q), .rd(rd_q),
    .first_b(first_b), .second_b(second_b)
  );

  i2cs_byte_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(accept), .len(req_len),
    .adv(adv_q), .remain(remain), .pos(pos)
  );

  // Step selection from the engine status code
  always_comb begin
    d_send1 = 1'b0; d_send2 = 1'b0; d_data = 1'b0; d_cont = 1'b0;
    d_store = 1'b0; d_stop = 1'b0; d_clr_ack = 1'b0; d_adv = 1'b0;
    d_reinit = 1'b0; d_res = RES_OK;
    if (act) begin
      if (!busy) begin
        d_stop = 1'b1;
      end else begin
        case (eng_status)
          ST_START, ST_RSTART: d_send1 = 1'b1;
          ST_WA_ACK, ST_WA2_ACK, ST_WD_ACK: begin
            if (ten_q && eng_status == ST_WA_ACK) d_send2 = 1'b1;
            else if (remain == ZERO || (abort_i && pos != ZERO)) d_stop = 1'b1;
            else begin
              d_data = 1'b1;
              d_adv  = 1'b1;
            end
          end
          ST_RA_ACK, ST_RA2_ACK: begin
            if (ten_q && eng_status == ST_RA_ACK) d_send2 = 1'b1;
            else if (remain == ZERO) d_stop = 1'b1;
            else begin
              d_cont    = 1'b1;
              d_clr_ack = (remain == ONE) || abort_i;
            end
          end
          ST_RD_ACK: begin
            d_store   = 1'b1;
            d_adv     = 1'b1;
            d_cont    = 1'b1;
            d_clr_ack = (remain == TWO) || abort_i;
          end
          ST_RD_NAK: begin
            d_store = 1'b1;
            d_adv   = 1'b1;
            d_stop  = 1'b1;
          end
          ST_WA_NAK, ST_WD_NAK, ST_RA_NAK: begin
            d_stop = 1'b1;
            d_res  = RES_NODEV;
          end
          default: begin
            d_stop   = 1'b1;
            d_reinit = 1'b1;
            d_res    = RES_IOERR;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; armed <= 1'b1;
      addr_q <= '0; ten_q <= 1'b0; rd_q <= 1'b0;
      ack_en <= 1'b0; inten <= 1'b0; adv_q <= 1'b0;
      data_we <= 1'b0; data_out <= 8'd0;
      ctl_we <= 1'b0; ctl_start <= 1'b0; ctl_stop <= 1'b0;
      eng_reinit <= 1'b0; buf_wr <= 1'b0; buf_wdata <= 8'd0;
      done <= 1'b0; result <= RES_OK;
    end else begin
      if (act) armed <= 1'b0;
      else if (!eng_iflg) armed <= 1'b1;

      data_we    <= d_send1 | d_send2 | d_data;
      ctl_we     <= accept | d_send1 | d_send2 | d_data | d_cont | d_stop;
      ctl_start  <= accept;
      ctl_stop   <= d_stop;
      buf_wr     <= d_store;
      adv_q      <= d_adv;
      eng_reinit <= d_reinit;
      done       <= 1'b0;

      if (d_send1)      data_out <= first_b;
      else if (d_send2) data_out <= second_b;
      else if (d_data)  data_out <= buf_rdata;
      if (d_store) buf_wdata <= eng_rdata;

      if (accept) begin
        busy   <= 1'b1;
        addr_q <= req_addr;
        ten_q  <= req_ten;
        rd_q   <= req_rd;
        ack_en <= 1'b1;
        inten  <= 1'b1;
        result <= RES_OK;
      end else begin
        if (d_clr_ack) ack_en <= 1'b0;
        if (d_stop) begin
          inten <= 1'b0;
          if (busy) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            result <= d_res;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2cs_seq_chk.sv
module i2cs_seq_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             data_we,
  input logic             ctl_we,
  input logic             ctl_start,
  input logic             ctl_stop,
  input logic             ctl_ack,
  input logic             ctl_inten,
  input logic             eng_reinit,
  input logic             buf_wr,
  input logic             done,
  input logic [1:0]       result
);
  assert_accept_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (ctl_we && ctl_start && ctl_ack && ctl_inten && !req_ready));

  assert_done_is_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ctl_we && ctl_stop));

  assert_store_not_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |-> !data_we);

  assert_stop_drops_inten_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_stop) |-> !ctl_inten);

  assert_reinit_ioerr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_reinit |-> (done && result == 2'd2));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> (done || $past(req_valid && req_ready)));
endmodule

bind i2c_xfer_seq i2cs_seq_chk #(.LEN_W(LEN_W)) u_seq_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .data_we(data_we), .ctl_we(ctl_we), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
  .ctl_ack(ctl_ack), .ctl_inten(ctl_inten), .eng_reinit(eng_reinit),
  .buf_wr(buf_wr), .done(done), .result(result)
);

// File: tb/i2c_xfer_seq_tb_top.sv
module i2c_xfer_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_ready;
  logic [9:0] req_addr = '0;
  logic       req_ten = 1'b0, req_rd = 1'b0;
  logic [7:0] req_len = '0;
  logic       abort_i = 1'b0;
  logic [7:0] eng_status = '0;
  logic       eng_iflg = 1'b0;
  logic [7:0] eng_rdata = '0;
  logic       data_we, ctl_we, ctl_start, ctl_stop, ctl_ack, ctl_inten, eng_reinit;
  logic [7:0] data_out, buf_rdata, buf_wdata;
  logic [7:0] buf_idx;
  logic       buf_wr, done;
  logic [1:0] result;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input logic [7:0] i);
    return 8'(i * 8'd29 + 8'h3C);
  endfunction
  assign buf_rdata = pat(buf_idx);

  i2c_xfer_seq dut_i (.*);

  // bench reference state
  bit       m_busy, m_ten, m_rd, m_ack, m_inten;
  bit [9:0] m_addr;
  int       m_cnt, m_pos;
  bit [1:0] m_res;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] first_byte();
    if (m_ten) return 8'hF0 | {5'd0, m_addr[9:8], 1'b0} | {7'd0, m_rd};
    return {m_addr[6:0], m_rd};
  endfunction

  task automatic request(input bit rd, input bit ten, input bit [9:0] a, input int len);
    @(negedge clk);
    chk("R1 ready idle", {63'd0, req_ready}, 64'd1);
    req_valid = 1; req_rd = rd; req_ten = ten; req_addr = a; req_len = 8'(len);
    @(negedge clk);
    req_valid = 0;
    chk("R1 start write", {58'd0, ctl_we, ctl_start, ctl_stop, ctl_ack, ctl_inten, req_ready},
        {58'd0, 6'b110110});
    chk("R12 result cleared", {62'd0, result}, 64'd0);
    m_busy = 1; m_rd = rd; m_ten = ten; m_addr = a; m_cnt = len; m_pos = 0;
    m_ack = 1; m_inten = 1; m_res = 0;
  endtask

  task automatic step(input logic [7:0] st, input logic [7:0] rb);
    logic e_dwe, e_cwe, e_stop, e_bwr, e_done, e_rei;
    logic [7:0] e_dout, e_bdat, e_idx;
    logic [1:0] e_res;
    string tag;
    e_dwe = 0; e_cwe = 0; e_stop = 0; e_bwr = 0; e_done = 0; e_rei = 0;
    e_dout = 0; e_bdat = 0; e_idx = 0; e_res = 0; tag = "R11";
    if (!m_busy) begin
      e_cwe = 1; e_stop = 1; m_inten = 0;
    end else begin
      case (st)
        8'h08, 8'h10: begin
          tag = m_ten ? "R3 first" : "R2"; e_dwe = 1; e_cwe = 1; e_dout = first_byte();
        end
        8'h18, 8'hD0, 8'h28, 8'h40, 8'hE0: begin
          if (m_ten && (st == 8'h18 || st == 8'h40)) begin
            tag = "R3 second"; e_dwe = 1; e_cwe = 1; e_dout = m_addr[7:0];
          end else if (st == 8'h40 || st == 8'hE0) begin
            e_cwe = 1;
            if (m_cnt == 0) begin tag = "R6 probe"; e_stop = 1; e_done = 1; end
            else begin tag = "R6 continue"; if (m_cnt == 1 || abort_i) m_ack = 0; end
          end else if (m_cnt == 0 || (abort_i && m_pos != 0)) begin
            tag = "R5"; e_cwe = 1; e_stop = 1; e_done = 1;
          end else begin
            tag = "R4"; e_dwe = 1; e_cwe = 1; e_dout = pat(8'(m_pos));
            m_pos++; m_cnt--;
          end
        end
        8'h50: begin
          tag = "R7"; e_cwe = 1; e_bwr = 1; e_bdat = rb; e_idx = 8'(m_pos);
          m_pos++; if (m_cnt > 0) m_cnt--;
          if (m_cnt == 1 || abort_i) m_ack = 0;
        end
        8'h58: begin
          tag = "R8"; e_cwe = 1; e_bwr = 1; e_bdat = rb; e_idx = 8'(m_pos);
          e_stop = 1; e_done = 1; m_pos++;
        end
        8'h20, 8'h30, 8'h48: begin
          tag = "R9"; e_cwe = 1; e_stop = 1; e_done = 1; e_res = 1;
        end
        default: begin
          tag = "R10"; e_cwe = 1; e_stop = 1; e_done = 1; e_res = 2; e_rei = 1;
        end
      endcase
      if (e_stop) begin m_inten = 0; m_busy = 0; m_res = e_res; end
    end
    @(negedge clk);
    eng_status = st; eng_rdata = rb; eng_iflg = 1;
    @(negedge clk);
    chk(tag,
        {data_we, data_we ? data_out : 8'd0, ctl_we, ctl_stop,
         ctl_we ? ctl_ack : 1'b0, ctl_we ? ctl_inten : 1'b0,
         buf_wr, buf_wr ? buf_wdata : 8'd0, buf_wr ? buf_idx : 8'd0,
         done, done ? result : 2'd0, eng_reinit, 29'd0},
        {e_dwe, e_dout, e_cwe, e_stop, e_cwe ? m_ack : 1'b0, e_cwe ? m_inten : 1'b0,
         e_bwr, e_bdat, e_idx, e_done, e_res, e_rei, 29'd0});
    eng_iflg = 0;
    @(negedge clk);
    if (e_done) chk("R12 done pulse", {63'd0, done}, 64'd0);
    chk("R12 result hold", {62'd0, result}, {62'd0, m_res});
  endtask

  task automatic run_xfer(input bit rd, input bit ten, input bit [9:0] a, input int len,
                          input int fault);
    int guard;
    request(rd, ten, a, len);
    step(($urandom % 2) ? 8'h08 : 8'h10, 8'h00);
    if (fault == 1) begin step(rd ? 8'h48 : 8'h20, 8'h00); return; end
    if (ten) begin
      step(rd ? 8'h40 : 8'h18, 8'h00);
      step(rd ? 8'hE0 : 8'hD0, 8'h00);
    end else step(rd ? 8'h40 : 8'h18, 8'h00);
    guard = 0;
    while (m_busy && guard < 40) begin
      guard++;
      if (rd) step(m_ack ? 8'h50 : 8'h58, 8'($urandom));
      else if (fault == 2 && m_pos >= 1) step(8'h30, 8'h00);
      else if (fault == 3 && m_pos >= 1) step(8'h38, 8'h00);
      else step(8'h28, 8'h00);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk("R1 reset state", {56'd0, req_ready, data_we, ctl_we, buf_wr, done, eng_reinit, result},
        {56'd0, 8'b1000_0000});
    rst_n = 1;
    @(negedge clk);
    // stray status while idle
    step(8'h28, 8'h00);
    // 7-bit write of three bytes
    run_xfer(0, 0, 10'h05A, 3, 0);
    // 10-bit read of two bytes
    run_xfer(1, 1, 10'h2A5, 2, 0);
    // probe
    run_xfer(1, 0, 10'h050, 0, 0);
    // write with zero length
    run_xfer(0, 0, 10'h011, 0, 0);
    // address not acknowledged
    run_xfer(0, 0, 10'h033, 2, 1);
    run_xfer(1, 1, 10'h1C3, 2, 1);
    // data NACK and bad status
    run_xfer(0, 0, 10'h044, 3, 2);
    run_xfer(0, 1, 10'h3FF, 3, 3);
    // abort mid-write: one byte then stop
    abort_i = 1;
    run_xfer(0, 0, 10'h022, 4, 0);
    run_xfer(1, 0, 10'h023, 4, 0);
    abort_i = 0;
    // request while busy is ignored
    request(0, 0, 10'h012, 1);
    @(negedge clk);
    chk("R1 busy not ready", {63'd0, req_ready}, 64'd0);
    req_valid = 1; req_addr = 10'h07F; req_rd = 1; req_len = 8'd9;
    @(negedge clk);
    req_valid = 0;
    step(8'h08, 8'h00);
    step(8'h18, 8'h00);
    step(8'h28, 8'h00);
    // random transfers
    for (int i = 0; i < 60; i++) begin
      bit rd, ten; int len, f;
      rd = 1'($urandom); ten = 1'($urandom);
      len = int'($urandom % 5);
      f = int'($urandom % 10);
      abort_i = (($urandom % 4) == 0);
      run_xfer(rd, ten, ten ? 10'($urandom) : {3'd0, 7'($urandom)}, len,
               (f < 3 && !rd) ? f + 1 : (f == 1 ? 1 : 0));
      abort_i = 0;
      repeat (int'($urandom % 3)) @(negedge clk);
      chk("R12 result idle hold", {62'd0, result}, {62'd0, m_res});
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule